// File: doc/BRIEF.md
# EEPROM Byte Write Sequencer

This block is the host side of a parallel EEPROM byte write. A client hands it one address and one data byte over a valid/ready handshake. The block then sequences the chip-enable, output-enable and write-enable strobes, the address lines and a tristated data bus. Setup, strobe width, hold, read width and the gap between polls are each a parameter counted in clock cycles.

Once the write strobe ends, the block waits for the device to finish programming instead of waiting out a fixed worst-case delay. A mode input picks how it watches the device, and the mode is captured when the request is accepted:

- **Data mode.** The block re-reads the address it just wrote. Programming is finished once the top data bit reads back equal to the written bit. While programming is still running, the device returns that bit inverted.
- **Ready mode.** The block samples an active-low busy line through a synchronizer and waits for it to be released. The line is open drain, so a pull-up is assumed.

If completion is not seen within a parameterized number of checks, the block raises an error flag and returns to idle. It takes a new request only in idle, so at most one write is ever in flight.

Top module: `eeprom_wr_seq`

## Requirements
- R1: After reset `req_ready` is 1; `ee_ce_n`, `ee_oe_n` and `ee_we_n` are 1; `ee_dq_oe`, `wr_done` and `wr_err` are 0.
- R2: A request is accepted only while `req_ready` is 1, which holds only in idle. `req_ready` drops the cycle after an acceptance. A `req_valid` raised while a write is in progress produces no device write.
- R3: `ee_we_n` is low only while `ee_ce_n` is low and `ee_oe_n` is high. When `ee_we_n` rises, `ee_addr` and `ee_dq_out` equal the accepted address and data.
- R4: `ee_we_n` stays low for exactly `WE_CYC` clock cycles per write.
- R5: `ee_dq_oe` is never 1 while `ee_oe_n` is 0. Each fall of `ee_oe_n` is preceded by a cycle with `ee_dq_oe` at 0.
- R6: With `cmp_mode`=0 (data mode), the block repeatedly reads the device. It completes, pulsing `wr_done` for one cycle, on the first read whose bit `DATA_W-1` equals that bit of the written data.
- R7: With `cmp_mode`=1 (ready mode), the block issues no read. It completes when the synchronized `ee_busy_n` is 1, where low means busy.
- R8: If `MAX_POLLS` consecutive checks all fail, the block sets `wr_err` to 1, gives no `wr_done`, and returns to idle.
- R9: If completion is first seen on check number `MAX_POLLS`, the result is success: `wr_done` pulses and `wr_err` stays 0.
- R10: `wr_err` stays set until the next request is accepted, and is 0 from the cycle after that acceptance.
- R11: Every poll read presents the address of the write being confirmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | ADDR_W | Byte address to write |
| req_data | input | DATA_W | Byte to write |
| cmp_mode | input | 1 | Completion method: 0 data readback, 1 busy line |
| wr_done | output | 1 | One-cycle pulse on confirmed write |
| wr_err | output | 1 | Completion not seen within the check limit |
| ee_ce_n | output | 1 | Device chip enable, active low |
| ee_oe_n | output | 1 | Device output enable, active low |
| ee_we_n | output | 1 | Device write enable, active low |
| ee_addr | output | ADDR_W | Device address lines |
| ee_dq_out | output | DATA_W | Data driven toward the device |
| ee_dq_oe | output | 1 | Drive enable for `ee_dq_out` |
| ee_dq_in | input | DATA_W | Data read from the device |
| ee_busy_n | input | 1 | Open-drain busy line, low while programming |

## Verification
Two events can land in the same decision cycle: the device reporting completion, and the check limit running out. The bench provokes this in data mode with a device model that returns the inverted top bit for a set number of reads.

- When the count is one less than `MAX_POLLS`, the correct match arrives on the last permitted check. That case must end in `wr_done` with `wr_err` low.
- When the count equals `MAX_POLLS`, the same final check fails. That case must end in `wr_err` with no done pulse.

Ready mode is exercised the same way, with a short and an over-long busy pulse.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STROBE,
      ST_RELEASE,
      ST_POLL_READ,
      ST_POLL_CHECK,
      ST_DONE
   } eewr_state_e;

   typedef enum logic {
      CMP_DATA = 1'b0,
      CMP_BUSY = 1'b1
   } eewr_cmp_e;

   function automatic int unsigned eewr_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/eewr_sync.sv
module eewr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else if (STAGES == 1) begin : g_single
         logic r1;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r1 <= 1'b1;
            else        r1 <= d;
         end
         assign q = r1;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '1;
            else        sr <= {sr[STAGES-2:0], d};
         end
         assign q = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/eewr_phase_cnt.sv
module eewr_phase_cnt #(
   parameter int unsigned CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          dec,
   output logic [CW-1:0] value,
   output logic          zero
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (load)                 cnt_q <= load_val;
      else if (dec && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign value = cnt_q;
   assign zero  = (cnt_q == '0);
endmodule

// File: rtl/eewr_hit_judge.sv
module eewr_hit_judge
   import eewr_pkg::*;
(
   input  eewr_cmp_e mode,
   input  logic      samp_msb,
   input  logic      wr_msb,
   input  logic      rdy_sync,
   output logic      hit
);
   always_comb begin
      case (mode)
         CMP_BUSY: hit = rdy_sync;
         default:  hit = (samp_msb == wr_msb);
      endcase
   end
endmodule

// File: rtl/eeprom_wr_seq.sv
module eeprom_wr_seq
   import eewr_pkg::*;
#(
   parameter int unsigned ADDR_W      = 13,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SETUP_CYC   = 2,
   parameter int unsigned WE_CYC      = 3,
   parameter int unsigned HOLD_CYC    = 1,
   parameter int unsigned RD_CYC      = 2,
   parameter int unsigned GAP_CYC     = 2,
   parameter int unsigned MAX_POLLS   = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic              cmp_mode,
   output logic              wr_done,
   output logic              wr_err,
   output logic              ee_ce_n,
   output logic              ee_oe_n,
   output logic              ee_we_n,
   output logic [ADDR_W-1:0] ee_addr,
   output logic [DATA_W-1:0] ee_dq_out,
   output logic              ee_dq_oe,
   input  logic [DATA_W-1:0] ee_dq_in,
   input  logic              ee_busy_n
);
   localparam int unsigned CNT_TOP = eewr_max(eewr_max(eewr_max(SETUP_CYC, WE_CYC),
                                              eewr_max(HOLD_CYC, RD_CYC)), GAP_CYC);
   localparam int unsigned CW  = $clog2(CNT_TOP + 1);
   localparam int unsigned PW  = $clog2(MAX_POLLS + 1);
   localparam int unsigned MSB = DATA_W - 1;

   generate
      if (SETUP_CYC < 1 || WE_CYC < 1 || HOLD_CYC < 1) begin : g_bad_write_timing
         $error("eeprom_wr_seq: setup, strobe and hold must each be at least one cycle");
      end
      if (RD_CYC < 1 || GAP_CYC < 1) begin : g_bad_poll_timing
         $error("eeprom_wr_seq: read width and poll gap must each be at least one cycle");
      end
      if (MAX_POLLS < 1) begin : g_bad_polls
         $error("eeprom_wr_seq: MAX_POLLS must be at least one");
      end
      if (DATA_W < 2 || ADDR_W < 1) begin : g_bad_width
         $error("eeprom_wr_seq: DATA_W must be at least 2 and ADDR_W at least 1");
      end
   endgenerate

   eewr_state_e       state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   eewr_cmp_e         mode_q;
   logic              samp_q;
   logic [PW-1:0]     poll_q;
   logic              err_q;

   logic              cnt_load, cnt_dec, cnt_zero;
   logic [CW-1:0]     cnt_val, cnt_q;
   logic              accept, samp_en, poll_inc, set_err;
   logic              rdy_sync, hit;
   logic              unused_dq_low;

   assign unused_dq_low = ^ee_dq_in[MSB-1:0];

   eewr_phase_cnt #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .dec      (cnt_dec),
      .value    (cnt_q),
      .zero     (cnt_zero)
   );

   eewr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ee_busy_n),
      .q     (rdy_sync)
   );

   eewr_hit_judge u_judge (
      .mode     (mode_q),
      .samp_msb (samp_q),
      .wr_msb   (data_q[MSB]),
      .rdy_sync (rdy_sync),
      .hit      (hit)
   );

   // Next-state and counter control
   always_comb begin
      state_d  = state_q;
      cnt_load = 1'b0;
      cnt_val  = '0;
      cnt_dec  = 1'b0;
      accept   = 1'b0;
      samp_en  = 1'b0;
      poll_inc = 1'b0;
      set_err  = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               accept   = 1'b1;
               state_d  = ST_SETUP;
               cnt_load = 1'b1;
               cnt_val  = CW'(SETUP_CYC - 1);
            end
         end
         ST_SETUP: begin
            if (cnt_zero) begin
               state_d  = ST_STROBE;
               cnt_load = 1'b1;
               cnt_val  = CW'(WE_CYC - 1);
            end else cnt_dec = 1'b1;
         end
         ST_STROBE: begin
            if (cnt_zero) begin
               state_d  = ST_RELEASE;
               cnt_load = 1'b1;
               cnt_val  = CW'(HOLD_CYC - 1);
            end else cnt_dec = 1'b1;
         end
         ST_RELEASE: begin
            if (cnt_zero) begin
               state_d  = ST_POLL_READ;
               cnt_load = 1'b1;
               cnt_val  = CW'(RD_CYC);
            end else cnt_dec = 1'b1;
         end
         ST_POLL_READ: begin
            if (cnt_zero) begin
               samp_en  = (mode_q == CMP_DATA);
               state_d  = ST_POLL_CHECK;
               cnt_load = 1'b1;
               cnt_val  = CW'(GAP_CYC);
            end else cnt_dec = 1'b1;
         end
         ST_POLL_CHECK: begin
            if (cnt_q == CW'(GAP_CYC)) begin
               if (hit) begin
                  state_d = ST_DONE;
               end else if (poll_q == PW'(MAX_POLLS - 1)) begin
                  state_d = ST_IDLE;
                  set_err = 1'b1;
               end else begin
                  poll_inc = 1'b1;
                  cnt_dec  = 1'b1;
               end
            end else if (cnt_zero) begin
               state_d  = ST_POLL_READ;
               cnt_load = 1'b1;
               cnt_val  = CW'(RD_CYC);
            end else cnt_dec = 1'b1;
         end
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
         mode_q  <= CMP_DATA;
         samp_q  <= 1'b0;
         poll_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            addr_q <= req_addr;
            data_q <= req_data;
            mode_q <= eewr_cmp_e'(cmp_mode);
            poll_q <= '0;
            err_q  <= 1'b0;
         end
         if (samp_en)  samp_q <= ee_dq_in[MSB];
         if (poll_inc) poll_q <= poll_q + 1'b1;
         if (set_err)  err_q  <= 1'b1;
      end
   end

   // Device pin decode
   always_comb begin
      ee_ce_n  = 1'b1;
      ee_oe_n  = 1'b1;
      ee_we_n  = 1'b1;
      ee_dq_oe = 1'b0;
      case (state_q)
         ST_SETUP, ST_RELEASE: begin
            ee_ce_n  = 1'b0;
            ee_dq_oe = 1'b1;
         end
         ST_STROBE: begin
            ee_ce_n  = 1'b0;
            ee_we_n  = 1'b0;
            ee_dq_oe = 1'b1;
         end
         ST_POLL_READ: begin
            if (mode_q == CMP_DATA) begin
               ee_ce_n = 1'b0;
               ee_oe_n = (cnt_q == CW'(RD_CYC));
            end
         end
         default: ;
      endcase
   end

   assign ee_addr   = addr_q;
   assign ee_dq_out = data_q;
   assign req_ready = (state_q == ST_IDLE);
   assign wr_done   = (state_q == ST_DONE);
   assign wr_err    = err_q;

   AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !ee_we_n |-> (!ee_ce_n && ee_oe_n)) else $error("strobe without CE or with OE"); // R3
   AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ee_we_n && $past(!ee_ce_n)) |-> ($stable(ee_addr) && $stable(ee_dq_out))) else $error("bus moved in strobe"); // R3
   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      !ee_oe_n |-> !ee_dq_oe) else $error("bus driven during read"); // R5
   AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ee_oe_n) |-> $past(!ee_dq_oe)) else $error("no turnaround before read"); // R5
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready) else $error("second request taken"); // R2
   AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> !wr_err) else $error("done together with error"); // R9
   AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      poll_q <= PW'(MAX_POLLS - 1)) else $error("poll count overran"); // R8
   AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !wr_err) else $error("error not cleared"); // R10
endmodule

// File: tb/tb_eeprom_wr_seq.sv
module tb_eeprom_wr_seq;
   localparam int AW = 13;
   localparam int DW = 8;
   localparam int WE_CYC = 3;
   localparam int MAX_POLLS = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic cmp_mode = 1'b0;
   logic req_ready, wr_done, wr_err;
   logic ee_ce_n, ee_oe_n, ee_we_n, ee_dq_oe, ee_busy_n;
   logic [AW-1:0] ee_addr;
   logic [DW-1:0] ee_dq_out, ee_dq_in;

   always #5 clk = ~clk;

   eeprom_wr_seq #(.ADDR_W(AW), .DATA_W(DW), .WE_CYC(WE_CYC), .MAX_POLLS(MAX_POLLS)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .cmp_mode(cmp_mode),
      .wr_done(wr_done), .wr_err(wr_err), .ee_ce_n(ee_ce_n), .ee_oe_n(ee_oe_n),
      .ee_we_n(ee_we_n), .ee_addr(ee_addr), .ee_dq_out(ee_dq_out), .ee_dq_oe(ee_dq_oe),
      .ee_dq_in(ee_dq_in), .ee_busy_n(ee_busy_n));

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Device model
   logic [AW-1:0] last_addr = '0;
   logic [DW-1:0] last_data = '0;
   logic [AW-1:0] exp_addr = '0;
   logic [DW-1:0] exp_data = '0;
   int k_cfg = 0, b_cfg = 0;
   int polls_left = 0, busy_left = 0;
   int wcount = 0, we_lo = 0;
   int viol_r3 = 0, viol_r4 = 0, viol_r5 = 0, viol_r11 = 0, reads = 0;
   logic prev_we = 1'b1, prev_oe = 1'b1, prev_dqoe = 1'b0;

   assign ee_busy_n = (busy_left == 0);
   assign ee_dq_in = (!ee_ce_n && !ee_oe_n) ?
      ((polls_left != 0 && ee_addr == last_addr) ? {~last_data[DW-1], last_data[DW-2:0]} : last_data)
      : '0;

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (busy_left > 0) busy_left <= busy_left - 1;
      if (!ee_we_n) begin
         we_lo <= we_lo + 1;
         if (ee_ce_n || !ee_oe_n) viol_r3 <= viol_r3 + 1;
      end
      if (!ee_oe_n && ee_dq_oe) viol_r5 <= viol_r5 + 1;
      if (prev_oe && !ee_oe_n && prev_dqoe) viol_r5 <= viol_r5 + 1;
      if (!ee_oe_n && ee_addr != last_addr) viol_r11 <= viol_r11 + 1;
      if (!prev_we && ee_we_n && rst_n) begin
         if (we_lo != WE_CYC) viol_r4 <= viol_r4 + 1;
         we_lo <= 0;
         if (ee_addr != exp_addr || ee_dq_out != exp_data) viol_r3 <= viol_r3 + 1;
         last_addr  <= ee_addr;
         last_data  <= ee_dq_out;
         wcount     <= wcount + 1;
         polls_left <= k_cfg;
         busy_left  <= b_cfg;
      end
      if (!prev_oe && ee_oe_n) begin
         reads <= reads + 1;
         if (polls_left > 0) polls_left <= polls_left - 1;
      end
      prev_we   <= ee_we_n;
      prev_oe   <= ee_oe_n;
      prev_dqoe <= ee_dq_oe;
   end

   typedef struct packed {
      logic          mode;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      logic [7:0]    hold;
      logic          exp_err;
   } vec_t;

   localparam vec_t VEC [0:6] = '{
      '{1'b0, 13'h0123, 8'hA5, 8'd0,   1'b0},   // R6 first read matches
      '{1'b0, 13'h1FFF, 8'h3C, 8'd2,   1'b0},   // R6 later match
      '{1'b0, 13'h0000, 8'h80, 8'd3,   1'b0},   // R9 match on last check
      '{1'b0, 13'h0AAA, 8'h7F, 8'd4,   1'b1},   // R8 never matches
      '{1'b1, 13'h0555, 8'h11, 8'd5,   1'b0},   // R7 short busy, R10 after error
      '{1'b1, 13'h1234, 8'hFE, 8'd200, 1'b1},   // R8 busy too long
      '{1'b0, 13'h0F0F, 8'h01, 8'd1,   1'b0}    // R6 one miss
   };

   task automatic issue(input logic mode, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int hold);
      @(negedge clk);
      exp_addr = a; exp_data = d;
      if (mode) begin k_cfg = 0; b_cfg = hold; end
      else      begin k_cfg = hold; b_cfg = 0; end
      cmp_mode = mode; req_addr = a; req_data = d; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R2 ready after accept", req_ready, 0);
      chk(wr_err == 1'b0, "R10 err cleared on accept", wr_err, 0);
   endtask

   task automatic wait_end(output bit got_done);
      got_done = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (wr_done) got_done = 1;
         if (req_ready) break;
      end
   endtask

   initial begin : watchdog
      wait (cyc > 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      bit got;
      int w0, r0;
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
      chk({ee_ce_n, ee_oe_n, ee_we_n} == 3'b111, "R1 strobes", {ee_ce_n, ee_oe_n, ee_we_n}, 7);
      chk({ee_dq_oe, wr_done, wr_err} == 3'b000, "R1 flags", {ee_dq_oe, wr_done, wr_err}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < 7; v++) begin
         w0 = wcount; r0 = reads;
         issue(VEC[v].mode, VEC[v].addr, VEC[v].data, int'(VEC[v].hold));
         wait_end(got);
         chk(wr_err == VEC[v].exp_err, "R8 error outcome", wr_err, VEC[v].exp_err);
         chk(got == !VEC[v].exp_err, "R6/R7/R9 done outcome", got, !VEC[v].exp_err);
         chk(wcount == w0 + 1, "R3 one device write", wcount - w0, 1);
         chk(last_addr == VEC[v].addr && last_data == VEC[v].data, "R3 latched byte",
             last_data, VEC[v].data);
         if (VEC[v].mode) chk(reads == r0, "R7 no reads in ready mode", reads - r0, 0);
         else if (!VEC[v].exp_err)
            chk(reads - r0 == int'(VEC[v].hold) + 1, "R6 reads to match", reads - r0,
                int'(VEC[v].hold) + 1);
         else chk(reads - r0 == MAX_POLLS, "R8 reads before error", reads - r0, MAX_POLLS);
         if (VEC[v].exp_err) begin
            repeat (3) @(negedge clk);
            chk(wr_err == 1'b1, "R10 error held in idle", wr_err, 1);
         end
      end

      // R2: requests while busy are ignored
      w0 = wcount;
      issue(1'b0, 13'h0246, 8'h5A, 2);
      for (int i = 0; i < 4; i++) begin
         req_addr = 13'h1357; req_data = 8'hC3; req_valid = 1'b1;
         @(negedge clk);
         chk(req_ready == 1'b0, "R2 ready low while busy", req_ready, 0);
      end
      req_valid = 1'b0;
      wait_end(got);
      chk(got == 1'b1, "R2 original write completes", got, 1);
      chk(wcount == w0 + 1, "R2 ignored request made no write", wcount - w0, 1);
      chk(last_addr == 13'h0246, "R2 address kept", last_addr, 13'h0246);

      // R1: reset in the middle of a strobe
      issue(1'b0, 13'h0010, 8'h99, 0);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(req_ready == 1'b1 && ee_we_n == 1'b1 && ee_dq_oe == 1'b0, "R1 reset mid-write",
          {req_ready, ee_we_n, ee_dq_oe}, 3'b110);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      chk(viol_r3 == 0, "R3 strobe gating and bus value", viol_r3, 0);
      chk(viol_r4 == 0, "R4 strobe width", viol_r4, 0);
      chk(viol_r5 == 0, "R5 bus turnaround", viol_r5, 0);
      chk(viol_r11 == 0, "R11 poll address", viol_r11, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule